// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who owns an external memory bus: the local bus cycle engine or an outside master. The outside master asks for the bus with a request line. The arbiter waits for any local cycle that is already running to finish. It then drives the latched chip selects to their inactive level for one step and releases all bus drivers. Only after that does it raise the grant acknowledge. While the bus is away, the arbiter can tell the outside master that the local side wants the bus back. The bus is retaken only when the outside master withdraws its request.

Each clock period of `clk_i` stands for one half-cycle step of the bus reference clock. The request is asynchronous and passes through a synchronizer. While the enable input is low, the request is ignored. A stall output tells the cycle engine not to start a new cycle while ownership is moving or the bus is away.

Top module: `ext_bus_hold_arbiter`

## Requirements
- R1: During and right after reset, `grant_o`=0, `reclaim_o`=0, `cs_oe_o`=1, `cs_park_o`=0, `bus_oe_o`=1 and `stall_o`=0.
- R2: The request passes a `SYNC_STAGES`-deep synchronizer (default 2). With no local cycle busy, a request that is first high at edge k starts the release at edge k+2.
- R3: While `cycle_busy_i` is high, the bus stays driven and `grant_o` stays low. `stall_o` is high from the edge where the request is taken until the arbiter returns to idle. The release starts at the first edge where the arbiter has seen the request and sees `cycle_busy_i` low.
- R4: The release step lasts exactly one cycle. In it, `cs_park_o`=1, `cs_oe_o`=1 (the chip selects are driven inactive), `bus_oe_o`=0 and `grant_o`=0.
- R5: At the next edge after the release step, `grant_o` goes to 1, and `cs_oe_o` and `bus_oe_o` go to 0. They stay in that state while the bus is held.
- R6: `reclaim_o` is high only while the bus is held. It is `bus_need_i` registered once. It can rise no earlier than `grant_o`.
- R7: Holding `reclaim_o` high does not bring the bus back. The bus stays released for as long as the request stays high.
- R8: A request that first reads low at edge m makes `grant_o` fall at edge m+2. All drivers turn back on and `reclaim_o` clears at the same edge. This happens whether or not `reclaim_o` was ever raised.
- R9: `stall_o` stays high for one cycle after `grant_o` falls, then clears.
- R10: While `ext_req_en_i` is low, a high request causes no change at any output.
- R11: A request withdrawn while the arbiter waits for a busy cycle returns the arbiter to idle without a grant, two edges after the withdrawal is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-cycle step clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_en_i | input | 1 | Enables the response to outside-master requests |
| ext_req_i | input | 1 | Asynchronous bus request from the outside master, active high |
| cycle_busy_i | input | 1 | A local bus cycle is running |
| bus_need_i | input | 1 | The local side has pending bus work |
| grant_o | output | 1 | Bus handed to the outside master |
| reclaim_o | output | 1 | Asks the outside master to give the bus back |
| cs_oe_o | output | 1 | Output enable for the chip-select drivers |
| cs_park_o | output | 1 | Forces the latched chip selects to their inactive level |
| bus_oe_o | output | 1 | Output enable for address, data and control drivers |
| stall_o | output | 1 | Holds the cycle engine off from starting a new cycle |

## Verification
The assertions assume two things about the inputs. The cycle engine obeys `stall_o`, so `cycle_busy_i` never goes high while the bus is released. The outside master does not change its request faster than the synchronizer can follow. The stimulus keeps to this in every sweep. `cycle_busy_i` is raised only together with a new request from idle, and it is only ever dropped after that. The request is held for at least two cycles at every change. After a withdrawal, idle is reached before the next request is raised.

// File: rtl/ebh_pkg.sv
package ebh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_END = 3'd1,
    ST_CS_PARK  = 3'd2,
    ST_HELD     = 3'd3,
    ST_REGAIN   = 3'd4
  } arb_state_e;
endpackage

// File: rtl/ebh_sync.sv
module ebh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ebh_fsm.sv
module ebh_fsm
  import ebh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       cycle_busy_i,
  output arb_state_e state_q_o,
  output arb_state_e state_d_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i) state_d = cycle_busy_i ? ST_WAIT_END : ST_CS_PARK;
      ST_WAIT_END: if (!req_i) state_d = ST_IDLE;
                   else if (!cycle_busy_i) state_d = ST_CS_PARK;
      ST_CS_PARK:  state_d = ST_HELD;
      ST_HELD:     if (!req_i) state_d = ST_REGAIN;
      ST_REGAIN:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // park step always lasts one cycle and leads to the held state
  p_park_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CS_PARK |=> state_q == ST_HELD);
  // held state is only entered through the park step
  p_held_via_park_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && $past(state_q) != ST_HELD) |-> $past(state_q) == ST_CS_PARK);
endmodule

// File: rtl/ebh_out.sv
module ebh_out
  import ebh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  arb_state_e state_q_i,
  input  arb_state_e state_d_i,
  input  logic       bus_need_i,
  output logic       grant_o,
  output logic       reclaim_o,
  output logic       cs_oe_o,
  output logic       cs_park_o,
  output logic       bus_oe_o,
  output logic       stall_o
);
  logic reclaim_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) reclaim_q <= 1'b0;
    else         reclaim_q <= (state_d_i == ST_HELD) && bus_need_i;

  always_comb begin
    grant_o   = 1'b0;
    cs_oe_o   = 1'b1;
    cs_park_o = 1'b0;
    bus_oe_o  = 1'b1;
    stall_o   = 1'b1;
    unique case (state_q_i)
      ST_IDLE:     stall_o = 1'b0;
      ST_WAIT_END: ;
      ST_CS_PARK: begin
        cs_park_o = 1'b1;
        bus_oe_o  = 1'b0;
      end
      ST_HELD: begin
        grant_o  = 1'b1;
        cs_oe_o  = 1'b0;
        bus_oe_o = 1'b0;
      end
      ST_REGAIN:   ;
      default:     stall_o = 1'b0;
    endcase
  end

  assign reclaim_o = reclaim_q;

  p_reclaim_only_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reclaim_o |-> grant_o);
  p_held_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (!cs_oe_o && !bus_oe_o));
endmodule

// File: rtl/ext_bus_hold_arbiter.sv
module ext_bus_hold_arbiter
  import ebh_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_req_en_i,
  input  logic ext_req_i,
  input  logic cycle_busy_i,
  input  logic bus_need_i,
  output logic grant_o,
  output logic reclaim_o,
  output logic cs_oe_o,
  output logic cs_park_o,
  output logic bus_oe_o,
  output logic stall_o
);
  logic       req_sync;
  logic       req_eff;
  arb_state_e state_q, state_d;

  ebh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_req_i),
    .q_o   (req_sync)
  );

  assign req_eff = req_sync && ext_req_en_i;

  ebh_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_eff),
    .cycle_busy_i(cycle_busy_i),
    .state_q_o   (state_q),
    .state_d_o   (state_d)
  );

  ebh_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_q_i (state_q),
    .state_d_i (state_d),
    .bus_need_i(bus_need_i),
    .grant_o   (grant_o),
    .reclaim_o (reclaim_o),
    .cs_oe_o   (cs_oe_o),
    .cs_park_o (cs_park_o),
    .bus_oe_o  (bus_oe_o),
    .stall_o   (stall_o)
  );

  p_busy_keeps_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_busy_i && bus_oe_o) |=> !grant_o);
  p_park_then_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_park_o |=> (!cs_park_o && !cs_oe_o && grant_o));
  p_grant_after_park_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(cs_park_o));
  p_regain_on_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_o) |-> !$past(req_eff));
  p_regain_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_o) |-> (stall_o && bus_oe_o && cs_oe_o && !reclaim_o));
endmodule

// File: tb/ext_bus_hold_arbiter_test.sv
`timescale 1ns/1ps
module ext_bus_hold_arbiter_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_req_en_i = 1'b0, ext_req_i = 1'b0, cycle_busy_i = 1'b0, bus_need_i = 1'b0;
  logic grant_o, reclaim_o, cs_oe_o, cs_park_o, bus_oe_o, stall_o;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // order: grant, reclaim, cs_oe, cs_park, bus_oe, stall
  localparam logic [5:0] P_IDLE = 6'b001010;
  localparam logic [5:0] P_WAIT = 6'b001011;
  localparam logic [5:0] P_PARK = 6'b001101;
  localparam logic [5:0] P_REGN = 6'b001011;

  always #10 clk_i = ~clk_i;

  ext_bus_hold_arbiter uut (.*);

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic expect6(string rid, logic [5:0] exp);
    logic [5:0] act;
    act = {grant_o, reclaim_o, cs_oe_o, cs_park_o, bus_oe_o, stall_o};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at %0t", rid, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] p_held(logic r);
    return {1'b1, r, 4'b0001};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    expect6("R1", P_IDLE);
    rst_ni = 1'b1;
    tick();
    expect6("R1", P_IDLE);
    ext_req_en_i = 1'b1;

    // R2..R9 sweep: busy length, reclaim want, held length
    for (int d = 0; d <= 4; d++) begin
      for (int nd = 0; nd <= 1; nd++) begin
        for (int h = 0; h <= 2; h++) begin
          int tr;
          tr = (d > 2) ? d : 2;
          ext_req_i    = 1'b1;
          cycle_busy_i = (d > 0);
          bus_need_i   = nd[0];
          for (int e = 0; e < tr; e++) begin
            tick();
            expect6(e >= 2 ? "R3" : "R2", e >= 2 ? P_WAIT : P_IDLE);
            if (e + 1 == d) cycle_busy_i = 1'b0;
          end
          cycle_busy_i = 1'b0;
          tick(); expect6("R4", P_PARK);
          tick(); expect6("R5 R6", p_held(nd[0]));
          for (int j = 0; j <= h + 1; j++) begin
            tick(); expect6("R7", p_held(nd[0]));
          end
          ext_req_i = 1'b0;
          tick(); expect6("R8", p_held(nd[0]));
          tick(); expect6("R8", p_held(nd[0]));
          tick(); expect6("R8", P_REGN);
          bus_need_i = 1'b0;
          tick(); expect6("R9", P_IDLE);
        end
      end
    end

    // R6: reclaim follows need one cycle later while held
    ext_req_i = 1'b1;
    repeat (4) tick();
    expect6("R6", p_held(1'b0));
    bus_need_i = 1'b1;
    tick(); expect6("R6", p_held(1'b1));
    bus_need_i = 1'b0;
    tick(); expect6("R6", p_held(1'b0));
    ext_req_i = 1'b0;
    repeat (3) tick();
    expect6("R8", P_REGN);
    tick(); expect6("R9", P_IDLE);

    // R10: disabled request has no effect
    ext_req_en_i = 1'b0;
    ext_req_i    = 1'b1;
    for (int e = 0; e < 6; e++) begin
      tick(); expect6("R10", P_IDLE);
    end
    ext_req_i = 1'b0;
    repeat (3) tick();
    ext_req_en_i = 1'b1;
    tick(); expect6("R10", P_IDLE);

    // R11: withdrawal while waiting for busy cycle
    ext_req_i    = 1'b1;
    cycle_busy_i = 1'b1;
    tick(); expect6("R11", P_IDLE);
    tick(); expect6("R11", P_IDLE);
    tick(); expect6("R11", P_WAIT);
    ext_req_i = 1'b0;
    tick(); expect6("R11", P_WAIT);
    tick(); expect6("R11", P_WAIT);
    tick(); expect6("R11", P_IDLE);
    cycle_busy_i = 1'b0;
    tick(); expect6("R11", P_IDLE);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule